// File: doc/BRIEF.md
# Selectable Half-Band Interpolation Cascade

The block raises the sample rate of a signed 16-bit stream by 1x, 2x, 4x or 8x. It does this with up to three fixed-coefficient half-band interpolate-by-two filters in series. The filters are a long 43-tap stage, a medium 19-tap stage and a short 11-tap stage. Stages that the selected rate does not need are bypassed. A zero-stuffing control replaces every filter with plain zero insertion.

Timing is set by `en_i`, a strobe at the final output rate. Each enable produces one output sample. The block marks the enables on which it takes a new input sample with `in_slot_o`. The source drives `in_valid_i` and `in_data_i` on those enables.

Each stage is polyphase. On an input slot the stage computes the even output. That output is the symmetric sum of the non-zero taps, with each pair of mirrored samples added before the multiply. Half a period later the stage emits the odd output, which is the input sample delayed by the filter's centre offset. `rate_i` and `zstuff_i` are meant to be changed only while the block is held in reset.

Top module: `hb_interp_cascade`

## Requirements
- R1: `rate_i` selects the factor F: 0 gives 1x, 1 gives 2x, 2 gives 4x and 3 gives 8x. `in_slot_o` is high on an enable exactly when the number of enables since reset, counted from zero, is a multiple of F. The first enable after reset is therefore a slot.
- R2: At 1x no filter is used. After each enable, `out_data_o` equals the sample taken on that enable.
- R3: 2x uses only the first stage. Its taps at even positions 0..20 are 8, -29, 67, -134, 244, -414, 673, -1079, 1772, -3280, 10364. The taps at odd positions are zero, except the centre (position 21), which is 16384. The response is symmetric.
- R4: 4x follows the first stage with the second. Its even-position taps 0..8 are 19, -120, 438, -1288, 5047, its centre (position 9) is 8192, and the response is symmetric.
- R5: 8x adds the third stage. Its even-position taps 0..4 are 7, -53, 302, its centre (position 5) is 512, and the response is symmetric.
- R6: Each filtered stage output is the full convolution of the zero-inserted input with the taps, plus half an LSB. It is shifted right arithmetically by log2 of the centre tap (14, 13 or 9) and clipped to the range -32768..32767.
- R7: The odd output of every stage reproduces the stage input sample exactly, so original samples pass through the filters unchanged.
- R8: With `zstuff_i` high, each used stage emits its input sample followed by one zero. At 8x every input sample is therefore followed by seven zeros.
- R9: A slot taken with `in_valid_i` low enters the filters as sample zero. Data and valid presented on enables that are not slots have no effect on the output.
- R10: Let y be the ideal output stream and k the enable index since reset. The output after enable k equals y[k-d], where d is 0 at 1x and 2x, 1 at 4x and 2 at 8x. Samples of y before index 0 are zero.
- R11: `out_data_o` does not change on a clock edge without `en_i`.
- R12: While `rst_ni` is low, all delay lines, stage outputs and the enable counter are cleared, and `out_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Output-rate enable; one output sample per enable |
| rate_i | input | 2 | Interpolation select: 0=1x, 1=2x, 2=4x, 3=8x |
| zstuff_i | input | 1 | Zero insertion in place of filtering |
| in_valid_i | input | 1 | Input sample qualifier, sampled on slots |
| in_data_i | input | 16 | Signed input sample |
| in_slot_o | output | 1 | This enable takes a new input sample |
| out_data_o | output | 16 | Signed output sample |

## Verification
Two behaviours are hard to reach from the ports.

The first is the last taps of the 43-tap stage. They show only after more than twenty input slots, and at 8x each slot is eight enables apart. The impulse runs are therefore long enough that the whole response of every stage, including its tail, passes through the output.

The second is saturation inside a stage. It occurs only when input samples line up with the signs of the coefficients. Full-scale random streams and a full-scale step, whose overshoot exceeds the 16-bit range, drive the path into clipping. The bench compares every output against an independent model that inserts zeros and then convolves.

Random enable gaps, invalid slots and garbage data on non-slot enables are mixed into the runs.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int DW    = 16;
  localparam int ACC_W = 40;
  localparam int NSTG  = 3;

  // window length (non-zero even-position taps) per stage
  function automatic int hb_len(input int stg);
    case (stg)
      1:       return 22;
      2:       return 10;
      default: return 6;
    endcase
  endfunction

  function automatic int hb_shift(input int stg);
    case (stg)
      1:       return 14;
      2:       return 13;
      default: return 9;
    endcase
  endfunction

  // coefficient of mirrored pair p (outermost first)
  function automatic int hb_tap(input int stg, input int p);
    case (stg)
      1: case (p)
           0: return 8;      1: return -29;   2: return 67;
           3: return -134;   4: return 244;   5: return -414;
           6: return 673;    7: return -1079; 8: return 1772;
           9: return -3280;  default: return 10364;
         endcase
      2: case (p)
           0: return 19;     1: return -120;  2: return 438;
           3: return -1288;  default: return 5047;
         endcase
      default: case (p)
           0: return 7;      1: return -53;   default: return 302;
         endcase
    endcase
  endfunction

  function automatic logic signed [DW-1:0] sat_round(input logic signed [ACC_W-1:0] acc,
                                                     input int sh);
    logic signed [ACC_W-1:0] half;
    logic signed [ACC_W-1:0] r;
    half = '0;
    half[sh-1] = 1'b1;
    r = (acc + half) >>> sh;
    if ((&r[ACC_W-1:DW-1]) || !(|r[ACC_W-1:DW-1])) return r[DW-1:0];
    else if (r[ACC_W-1]) return {1'b1, {(DW-1){1'b0}}};
    else return {1'b0, {(DW-1){1'b1}}};
  endfunction
endpackage

// File: rtl/hb_strobe.sv
module hb_strobe
  import hb_pkg::*;
#(
  parameter int SIDX = 1
) (
  input  logic       en_i,
  input  logic [2:0] ph_i,
  input  logic [1:0] rate_i,
  output logic       in_stb_o,
  output logic       mid_stb_o
);
  logic [2:0] rel, mask, half;
  logic       act;

  // each later stage samples one enable after the previous stage updates
  assign rel = ph_i - 3'(SIDX - 1);

  always_comb begin
    act  = 1'b1;
    mask = 3'd0;
    half = 3'd0;
    case (int'(rate_i) - SIDX + 1)
      1:       begin mask = 3'd1; half = 3'd1; end
      2:       begin mask = 3'd3; half = 3'd2; end
      3:       begin mask = 3'd7; half = 3'd4; end
      default: act = 1'b0;
    endcase
  end

  assign in_stb_o  = en_i && act && ((rel & mask) == 3'd0);
  assign mid_stb_o = en_i && act && ((rel & mask) == half);
endmodule

// File: rtl/hb_stage.sv
module hb_stage
  import hb_pkg::*;
#(
  parameter int STG = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_stb_i,
  input  logic                 mid_stb_i,
  input  logic                 zstuff_i,
  input  logic signed [DW-1:0] in_data_i,
  output logic signed [DW-1:0] out_data_o
);
  localparam int L  = hb_len(STG);
  localparam int NP = L / 2;
  localparam int D  = (L - 2) / 2;
  localparam int SH = hb_shift(STG);

  logic signed [DW-1:0]    line_q [L-1];
  logic signed [DW-1:0]    win    [L];
  logic signed [ACC_W-1:0] prod   [NP];
  logic signed [ACC_W-1:0] acc;
  logic signed [DW-1:0]    even_val, odd_val;

  always_comb begin
    win[0] = in_data_i;
    for (int i = 1; i < L; i++) win[i] = line_q[i-1];
  end

  for (genvar p = 0; p < NP; p++) begin : g_pair
    assign prod[p] = (ACC_W'(win[p]) + ACC_W'(win[L-1-p])) * ACC_W'(hb_tap(STG, p));
  end

  always_comb begin
    acc = '0;
    for (int p = 0; p < NP; p++) acc = acc + prod[p];
  end

  assign even_val = zstuff_i ? in_data_i : sat_round(acc, SH);
  assign odd_val  = zstuff_i ? '0 : line_q[D];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < L - 1; i++) line_q[i] <= '0;
      out_data_o <= '0;
    end else if (in_stb_i) begin
      line_q[0] <= in_data_i;
      for (int i = 1; i < L - 1; i++) line_q[i] <= line_q[i-1];
      out_data_o <= even_val;
    end else if (mid_stb_i) begin
      out_data_o <= odd_val;
    end
  end
endmodule

// File: rtl/hb_interp_cascade.sv
module hb_interp_cascade
  import hb_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [1:0]           rate_i,
  input  logic                 zstuff_i,
  input  logic                 in_valid_i,
  input  logic signed [DW-1:0] in_data_i,
  output logic                 in_slot_o,
  output logic signed [DW-1:0] out_data_o
);
  logic [2:0]           ph_q;
  logic signed [DW-1:0] smp, byp_q;
  logic signed [DW-1:0] st_in  [NSTG];
  logic signed [DW-1:0] st_out [NSTG];
  logic [NSTG-1:0]      in_stb, mid_stb;

  assign smp = in_valid_i ? in_data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      byp_q <= '0;
    end else if (en_i) begin
      ph_q  <= ph_q + 3'd1;
      byp_q <= smp;
    end
  end

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    if (s == 0) begin : g_head
      assign st_in[s] = smp;
    end else begin : g_link
      assign st_in[s] = st_out[s-1];
    end

    hb_strobe #(.SIDX(s + 1)) u_stb (
      .en_i      (en_i),
      .ph_i      (ph_q),
      .rate_i    (rate_i),
      .in_stb_o  (in_stb[s]),
      .mid_stb_o (mid_stb[s])
    );

    hb_stage #(.STG(s + 1)) u_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .in_stb_i   (in_stb[s]),
      .mid_stb_i  (mid_stb[s]),
      .zstuff_i   (zstuff_i),
      .in_data_i  (st_in[s]),
      .out_data_o (st_out[s])
    );
  end

  assign in_slot_o = (rate_i == 2'd0) ? en_i : in_stb[0];

  always_comb begin
    case (rate_i)
      2'd0:    out_data_o = byp_q;
      2'd1:    out_data_o = st_out[0];
      2'd2:    out_data_o = st_out[1];
      default: out_data_o = st_out[2];
    endcase
  end
endmodule

// File: rtl/hb_interp_cascade_chk.sv
module hb_interp_cascade_chk (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic [1:0]         rate_i,
  input logic               zstuff_i,
  input logic               in_valid_i,
  input logic signed [15:0] in_data_i,
  input logic               in_slot_o,
  input logic signed [15:0] out_data_o
);
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(out_data_o) || !$stable(rate_i)));

  assert_bypass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rate_i == 2'd0) |=>
      (rate_i != 2'd0 || out_data_o == $past(in_valid_i ? in_data_i : 16'sd0)));

  assert_zs_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rate_i == 2'd1 && zstuff_i && !in_slot_o) |=>
      (rate_i != 2'd1 || out_data_o == 16'sd0));

  assert_zs_slot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rate_i == 2'd1 && zstuff_i && in_slot_o) |=>
      (rate_i != 2'd1 || out_data_o == $past(in_valid_i ? in_data_i : 16'sd0)));

  assert_slot_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i == 2'd3 && in_slot_o) |=> (!in_slot_o || rate_i != 2'd3));
endmodule

bind hb_interp_cascade hb_interp_cascade_chk u_chk (.*);

// File: tb/hb_interp_cascade_tb.sv
`timescale 1ns/1ps
module hb_interp_cascade_tb;
  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               en_i = 1'b0;
  logic [1:0]         rate_i = 2'd0;
  logic               zstuff_i = 1'b0;
  logic               in_valid_i = 1'b0;
  logic signed [15:0] in_data_i = '0;
  logic               in_slot_o;
  logic signed [15:0] out_data_o;

  always #2.5 clk_i = ~clk_i;

  hb_interp_cascade u_dut (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  string cur_tag = "";
  int exp_q[$];
  int cur[$], nxt[$];
  int tick_no = 0;

  localparam int T1[11] = '{8, -29, 67, -134, 244, -414, 673, -1079, 1772, -3280, 10364};
  localparam int T2[5]  = '{19, -120, 438, -1288, 5047};
  localparam int T3[3]  = '{7, -53, 302};

  function automatic int nh(int stg);
    return (stg == 1) ? 11 : (stg == 2) ? 5 : 3;
  endfunction

  function automatic int centre(int stg);
    return (stg == 1) ? 16384 : (stg == 2) ? 8192 : 512;
  endfunction

  function automatic int tap(int stg, int j);
    int n, c, i;
    n = 4 * (nh(stg) - 1) + 3;
    c = (n - 1) / 2;
    if (j == c) return centre(stg);
    if (j % 2 == 1) return 0;
    i = (j < c) ? j / 2 : (n - 1 - j) / 2;
    return (stg == 1) ? T1[i] : (stg == 2) ? T2[i] : T3[i];
  endfunction

  // zero insertion, then full convolution, rounding and clipping
  task automatic model_stage(int stg, bit zs);
    int u[$];
    int n, sh;
    longint acc;
    n = 4 * (nh(stg) - 1) + 3;
    sh = $clog2(centre(stg));
    u = {};
    foreach (cur[i]) begin u.push_back(cur[i]); u.push_back(0); end
    nxt = {};
    for (int k = 0; k < u.size(); k++) begin
      if (zs) nxt.push_back(u[k]);
      else begin
        acc = 0;
        for (int j = 0; j < n; j++)
          if (k - j >= 0) acc += longint'(tap(stg, j)) * longint'(u[k-j]);
        acc = (acc + (longint'(1) << (sh - 1))) >>> sh;
        if (acc > 32767) acc = 32767;
        if (acc < -32768) acc = -32768;
        nxt.push_back(int'(acc));
      end
    end
    cur = nxt;
  endtask

  task automatic check(bit ok, string tag, int got, int exp, string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s tick %0d: got %0d expected %0d", tag, what, tick_no, got, exp);
    end
  endtask

  // monitor: one expected sample per enable
  logic mon_pend = 1'b0;
  always @(posedge clk_i) mon_pend <= rst_ni && en_i;
  always @(negedge clk_i) begin
    if (mon_pend) begin
      if (exp_q.size() == 0) check(1'b0, cur_tag, int'(out_data_o), 0, "unexpected output");
      else begin
        int e;
        e = exp_q.pop_front();
        check(int'(out_data_o) == e, cur_tag, int'(out_data_o), e, "output");
      end
    end
  end

  // kind: 0 impulse, 1 random, 2 random with invalid slots, 3 full-scale step
  task automatic run_case(int rate, bit zs, int nin, int kind, bit gaps, string tag);
    int xs[$];
    bit vl[$];
    int f, lat, prev;
    bit slot;
    rst_ni = 1'b0; en_i = 1'b0; in_valid_i = 1'b0;
    rate_i = 2'(rate); zstuff_i = zs;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    cur_tag = tag;
    tick_no = 0;
    check(out_data_o == 16'sd0, "R12", int'(out_data_o), 0, "reset output");
    check(in_slot_o == 1'b0, "R12", int'(in_slot_o), 0, "slot without enable");
    f = 1 << rate;
    lat = (rate > 0) ? rate - 1 : 0;
    xs = {}; vl = {}; cur = {};
    for (int n = 0; n < nin; n++) begin
      int x;
      bit v;
      v = 1'b1;
      case (kind)
        0: x = (n == 0) ? 20000 : 0;
        1: x = int'($signed(16'($urandom)));
        2: begin x = int'($signed(16'($urandom))); v = ($urandom % 3) != 0; end
        default: x = (n < nin / 2) ? 32767 : -32768;
      endcase
      xs.push_back(x); vl.push_back(v);
      cur.push_back(v ? x : 0);
    end
    for (int s = 1; s <= rate; s++) model_stage(s, zs);
    for (int k = 0; k < nin * f; k++) exp_q.push_back((k - lat < 0) ? 0 : cur[k - lat]);

    for (int k = 0; k < nin * f; k++) begin
      if (gaps && ($urandom % 3) == 0) begin
        en_i = 1'b0; in_valid_i = 1'b1; in_data_i = 16'($urandom);
        prev = int'(out_data_o);
        @(negedge clk_i);
        check(int'(out_data_o) == prev, "R11", int'(out_data_o), prev, "hold without enable");
      end
      tick_no = k;
      slot = (k % f) == 0;
      en_i = 1'b1;
      if (slot) begin
        in_valid_i = vl[k / f];
        in_data_i  = vl[k / f] ? 16'(xs[k / f]) : 16'($urandom);
      end else begin
        in_valid_i = 1'b1;           // R9: non-slot data must be ignored
        in_data_i  = 16'($urandom);
      end
      #1;
      check(in_slot_o == slot, "R1", int'(in_slot_o), int'(slot), "slot flag");
      @(negedge clk_i);
    end
    en_i = 1'b0;
    @(negedge clk_i);
    #1;
    check(exp_q.size() == 0, tag, exp_q.size(), 0, "samples left");
    exp_q = {};
  endtask

  initial begin
    run_case(0, 1'b0, 24, 0, 1'b0, "R2 R12");
    run_case(0, 1'b0, 40, 2, 1'b1, "R2 R9");
    run_case(1, 1'b0, 30, 0, 1'b0, "R3 R7 R10");
    run_case(1, 1'b0, 40, 1, 1'b1, "R3 R6");
    run_case(2, 1'b0, 30, 0, 1'b0, "R4 R7 R10");
    run_case(2, 1'b0, 40, 2, 1'b1, "R4 R9");
    run_case(3, 1'b0, 30, 0, 1'b0, "R5 R7 R10");
    run_case(3, 1'b0, 40, 1, 1'b1, "R5 R6");
    run_case(3, 1'b0, 40, 3, 1'b0, "R6 R5");
    run_case(1, 1'b1, 16, 2, 1'b1, "R8 R9");
    run_case(2, 1'b1, 16, 1, 1'b0, "R8");
    run_case(3, 1'b1, 16, 1, 1'b1, "R8 R1");
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got running expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule